// File: doc/BRIEF.md
# Hash Engine Register Front-End

This block is the register file that software uses to drive a hash accelerator. A 32-bit register bus writes a source pointer, a digest pointer, a key-buffer pointer and a byte count. Each value is trimmed to the bits that are actually built. A write to the hash command register hands a job to a separate hash core by pulsing a start strobe. The core reports completion with a one-cycle done pulse. The block shows a busy flag while the job runs, then a sticky interrupt flag. The master clears that flag by writing a one to it.

Two sibling engines, crypto and RSA, report completion through their own done inputs. Each sets its own sticky flag in the shared status word. The interrupt output is high while any of the three flags is set. Reads are combinational from the offset, so the read data follows the address in the same cycle. Writes take effect at the clock edge that samples them.

Top module: `hash_reg_front`

## Requirements
- R1: After reset, every mapped register reads zero: general command 0x10, status 0x1C, source 0x20, digest 0x24, key buffer 0x28, length 0x2C and hash command 0x30. Also after reset, `irq` and `core_start` are low.
- R2: The source register (0x20) and the key buffer register (0x28) keep only bits below ADDR_BITS. With the default of 31, an all-ones write reads back 0x7FFFFFFF.
- R3: The digest register (0x24) keeps the same address bits and also forces bits [2:0] to zero. With the default, an all-ones write reads back 0x7FFFFFF8.
- R4: The length register (0x2C) keeps only bits below LEN_BITS. With the default of 28, an all-ones write reads back 0x0FFFFFFF.
- R5: The general command register (0x10) stores all 32 bits. An accepted hash command write (0x30) stores only the defined command bits 2, 3, 4, 5, 6, 10 and 18, which form the mask 0x0004047C.
- R6: A write to 0x30 while the hash engine is idle launches a job. At that edge the hash busy flag (status bit 0) sets, and `core_start` is high for exactly the following cycle. While the job runs, status reads 0x00000001.
- R7: A `core_done` pulse while busy clears bit 0 and sets the hash interrupt flag (status bit 9) at the same edge. Status then reads exactly 0x00000200, and `irq` is high.
- R8: The status interrupt bits 9, 12 and 13 are write-one-to-clear. A write with zero in a flag's bit leaves that flag unchanged.
- R9: A pulse on `crypto_done` sets status bit 12, and a pulse on `rsa_done` sets status bit 13. `irq` is the OR of bits 9, 12 and 13.
- R10: A write to 0x30 while the hash engine is busy is ignored. It produces no `core_start`, and the hash command readback keeps its previous value.
- R11: If a completion and a write-one-to-clear of the same flag fall in the same cycle, the completion wins and the flag stays set.
- R12: Reads of unmapped offsets return zero. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | OFS_W | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| core_start | output | 1 | One-cycle launch strobe to the hash core |
| core_done | input | 1 | One-cycle completion pulse from the hash core |
| core_src | output | 32 | Source pointer to the core |
| core_dst | output | 32 | Digest pointer to the core |
| core_len | output | 32 | Byte count to the core |
| core_cmd | output | 32 | Command of the launched job |
| crypto_done | input | 1 | Completion pulse from the crypto engine |
| rsa_done | input | 1 | Completion pulse from the RSA engine |
| irq | output | 1 | Interrupt request |

## Verification
Two events can land on the hash interrupt flag in the same cycle: a done pulse from the core and a write-one-to-clear from the bus. The bench raises `core_done` and a status write of 0x200 on the same clock edge, with a job in flight. It then reads status and expects 0x200 and `irq` still high, because the new completion must not be lost. The same cycle is also probed with a command write that arrives while busy. That write must not pulse `core_start` and must not change the stored command.

// File: rtl/hash_reg_front.sv
module hash_reg_front #(
  parameter int ADDR_BITS = 31,
  parameter int LEN_BITS  = 28,
  parameter int OFS_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [OFS_W-1:0] reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             core_start,
  input  logic             core_done,
  output logic [31:0]      core_src,
  output logic [31:0]      core_dst,
  output logic [31:0]      core_len,
  output logic [31:0]      core_cmd,
  input  logic             crypto_done,
  input  logic             rsa_done,
  output logic             irq
);
  localparam logic [31:0] ADDR_MASK = (ADDR_BITS >= 32) ? 32'hFFFF_FFFF : ((32'd1 << ADDR_BITS) - 32'd1);
  localparam logic [31:0] LEN_MASK  = (LEN_BITS  >= 32) ? 32'hFFFF_FFFF : ((32'd1 << LEN_BITS)  - 32'd1);
  localparam logic [31:0] DST_MASK  = ADDR_MASK & ~32'h7;
  localparam logic [31:0] CMD_MASK  = 32'h0004_047C;
  localparam logic [OFS_W-1:0] OFS_GEN  = OFS_W'('h10);
  localparam logic [OFS_W-1:0] OFS_STS  = OFS_W'('h1C);
  localparam logic [OFS_W-1:0] OFS_SRC  = OFS_W'('h20);
  localparam logic [OFS_W-1:0] OFS_DST  = OFS_W'('h24);
  localparam logic [OFS_W-1:0] OFS_KEY  = OFS_W'('h28);
  localparam logic [OFS_W-1:0] OFS_LEN  = OFS_W'('h2C);
  localparam logic [OFS_W-1:0] OFS_HCMD = OFS_W'('h30);

  logic [31:0] gen_q, src_q, dst_q, key_q, len_q, hcmd_q;
  logic        hash_busy, hash_irq, crypto_irq, rsa_irq, start_q;

  logic wr_sts, wr_hcmd, launch, hash_fin;
  assign wr_sts   = reg_wr && (reg_addr == OFS_STS);
  assign wr_hcmd  = reg_wr && (reg_addr == OFS_HCMD);
  assign launch   = wr_hcmd && !hash_busy;
  assign hash_fin = core_done && hash_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q <= '0;
      src_q <= '0;
      dst_q <= '0;
      key_q <= '0;
      len_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_GEN: gen_q <= reg_wdata;
        OFS_SRC: src_q <= reg_wdata & ADDR_MASK;
        OFS_DST: dst_q <= reg_wdata & DST_MASK;
        OFS_KEY: key_q <= reg_wdata & ADDR_MASK;
        OFS_LEN: len_q <= reg_wdata & LEN_MASK;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcmd_q    <= '0;
      start_q   <= 1'b0;
      hash_busy <= 1'b0;
    end else begin
      start_q <= launch;
      if (launch) begin
        hcmd_q    <= reg_wdata & CMD_MASK;
        hash_busy <= 1'b1;
      end else if (hash_fin) begin
        hash_busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hash_irq   <= 1'b0;
      crypto_irq <= 1'b0;
      rsa_irq    <= 1'b0;
    end else begin
      if (hash_fin)                      hash_irq   <= 1'b1;
      else if (wr_sts && reg_wdata[9])   hash_irq   <= 1'b0;
      if (crypto_done)                   crypto_irq <= 1'b1;
      else if (wr_sts && reg_wdata[12])  crypto_irq <= 1'b0;
      if (rsa_done)                      rsa_irq    <= 1'b1;
      else if (wr_sts && reg_wdata[13])  rsa_irq    <= 1'b0;
    end
  end

  logic [31:0] sts_word;
  assign sts_word = {18'd0, rsa_irq, crypto_irq, 2'd0, hash_irq, 8'd0, hash_busy};

  always_comb begin
    case (reg_addr)
      OFS_GEN:  reg_rdata = gen_q;
      OFS_STS:  reg_rdata = sts_word;
      OFS_SRC:  reg_rdata = src_q;
      OFS_DST:  reg_rdata = dst_q;
      OFS_KEY:  reg_rdata = key_q;
      OFS_LEN:  reg_rdata = len_q;
      OFS_HCMD: reg_rdata = hcmd_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign core_start = start_q;
  assign core_src   = src_q;
  assign core_dst   = dst_q;
  assign core_len   = len_q;
  assign core_cmd   = hcmd_q;
  assign irq        = hash_irq | crypto_irq | rsa_irq;
endmodule

module hash_reg_front_chk #(
  parameter int OFS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [OFS_W-1:0] reg_addr,
  input logic             w1c_hash,
  input logic             core_start,
  input logic             core_done,
  input logic [31:0]      core_cmd,
  input logic             irq,
  input logic             hash_busy,
  input logic             hash_irq
);
  localparam logic [OFS_W-1:0] OFS_STS  = OFS_W'('h1C);
  localparam logic [OFS_W-1:0] OFS_HCMD = OFS_W'('h30);

  assert_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_HCMD && !hash_busy) |=> (hash_busy && core_start));

  assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> hash_busy);

  assert_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done && hash_busy) |=> (!hash_busy && hash_irq));

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_HCMD && hash_busy) |=> (!core_start && $stable(core_cmd)));

  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_STS && w1c_hash && !(core_done && hash_busy)) |=> !hash_irq);

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_STS && w1c_hash && core_done && hash_busy) |=> hash_irq);

  assert_irq_or_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hash_irq |-> irq);
endmodule

bind hash_reg_front hash_reg_front_chk #(.OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .w1c_hash(reg_wdata[9]), .core_start(core_start), .core_done(core_done),
  .core_cmd(core_cmd), .irq(irq), .hash_busy(hash_busy), .hash_irq(hash_irq)
);

// File: tb/hash_reg_front_tb.sv
module hash_reg_front_tb;
  localparam int TB_ADDR_BITS = 31;
  localparam int TB_LEN_BITS  = 28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        core_start, core_done = 1'b0, crypto_done = 1'b0, rsa_done = 1'b0, irq;
  logic [31:0] core_src, core_dst, core_len, core_cmd;

  int n_chk = 0, n_fail = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  hash_reg_front #(.ADDR_BITS(TB_ADDR_BITS), .LEN_BITS(TB_LEN_BITS), .OFS_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_start(core_start),
    .core_done(core_done), .core_src(core_src), .core_dst(core_dst),
    .core_len(core_len), .core_cmd(core_cmd), .crypto_done(crypto_done),
    .rsa_done(rsa_done), .irq(irq)
  );

  function automatic logic [31:0] amask();
    return (32'd1 << TB_ADDR_BITS) - 32'd1;
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] ofs, input logic [31:0] v);
    case (ofs)
      8'h10: return v;
      8'h20, 8'h28: return v & amask();
      8'h24: return v & amask() & 32'hFFFF_FFF8;
      8'h2C: return v & ((32'd1 << TB_LEN_BITS) - 32'd1);
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_wr = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) core_done = 1'b1;
    else if (which == 1) crypto_done = 1'b1;
    else rsa_done = 1'b1;
    @(negedge clk);
    core_done = 1'b0; crypto_done = 1'b0; rsa_done = 1'b0;
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic [7:0] ofs_list [6] = '{8'h10, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h14};
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    foreach (ofs_list[i]) begin
      rd(ofs_list[i], d); check("R1 reset", d, 0);
    end
    rd(8'h1C, d); check("R1 status", d, 0);
    rd(8'h30, d); check("R1 hcmd", d, 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 start", {31'd0, core_start}, 0);

    // R2..R5 all-ones masks
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, d); check("R2 src", d, 32'h7FFF_FFFF);
    wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, d); check("R2 key", d, 32'h7FFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF); rd(8'h24, d); check("R3 dst", d, 32'h7FFF_FFF8);
    check("R3 core_dst", core_dst, 32'h7FFF_FFF8);
    wr(8'h2C, 32'hFFFF_FFFF); rd(8'h2C, d); check("R4 len", d, 32'h0FFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, d); check("R5 gen", d, 32'hFFFF_FFFF);
    wr(8'h20, 0); wr(8'h24, 0); wr(8'h28, 0); wr(8'h2C, 0); wr(8'h10, 0);
    rd(8'h20, d); check("R2 src zero", d, 0);
    rd(8'h24, d); check("R3 dst zero", d, 0);

    // R12 unmapped
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, d); check("R12 unmapped read", d, 0);
    rd(8'h10, d); check("R12 gen untouched", d, 0);
    wr(8'h34, 32'hA5A5_A5A5); rd(8'h34, d); check("R12 unmapped 0x34", d, 0);
    rd(8'h30, d); check("R12 hcmd untouched", d, 0);

    // R6 launch
    wr(8'h20, 32'h0000_1000); wr(8'h24, 32'h0100_1000); wr(8'h2C, 32'd3);
    check("R6 core_src", core_src, 32'h0000_1000);
    check("R6 core_len", core_len, 32'd3);
    wr(8'h30, 32'h0000_0058);
    check("R6 start high", {31'd0, core_start}, 1);
    rd(8'h1C, d); check("R6 busy status", d, 32'h1);
    rd(8'h30, d); check("R5 hcmd store", d, 32'h58);
    @(negedge clk);
    check("R6 start one cycle", {31'd0, core_start}, 0);

    // R10 write while busy
    wr(8'h30, 32'h0000_0020);
    check("R10 no start", {31'd0, core_start}, 0);
    rd(8'h30, d); check("R10 hcmd kept", d, 32'h58);

    // R7 done
    pulse(0);
    rd(8'h1C, d); check("R7 status", d, 32'h200);
    check("R7 irq", {31'd0, irq}, 1);

    // R8 W1C
    wr(8'h1C, 0); rd(8'h1C, d); check("R8 zero write keeps", d, 32'h200);
    wr(8'h1C, 32'h200); rd(8'h1C, d); check("R8 clear", d, 0);
    check("R8 irq low", {31'd0, irq}, 0);

    // R5 command mask
    wr(8'h30, 32'hFFFF_FFFF);
    check("R6 start again", {31'd0, core_start}, 1);
    rd(8'h30, d); check("R5 hcmd mask", d, 32'h0004_047C);
    check("R5 core_cmd", core_cmd, 32'h0004_047C);
    pulse(0);
    wr(8'h1C, 32'h200);

    // R9 sibling engines
    pulse(1); rd(8'h1C, d); check("R9 crypto", d, 32'h1000);
    check("R9 irq crypto", {31'd0, irq}, 1);
    pulse(2); rd(8'h1C, d); check("R9 rsa", d, 32'h3000);
    wr(8'h1C, 32'h1000); rd(8'h1C, d); check("R8 crypto clear", d, 32'h2000);
    check("R9 irq rsa only", {31'd0, irq}, 1);
    wr(8'h1C, 32'h2000); rd(8'h1C, d); check("R8 rsa clear", d, 0);
    check("R9 irq none", {31'd0, irq}, 0);

    // R11 done and clear same cycle
    wr(8'h30, 32'h0000_0060);
    @(negedge clk);
    core_done = 1'b1; reg_wr = 1'b1; reg_addr = 8'h1C; reg_wdata = 32'h200;
    @(negedge clk);
    core_done = 1'b0; reg_wr = 1'b0;
    rd(8'h1C, d); check("R11 set wins", d, 32'h200);
    check("R11 irq", {31'd0, irq}, 1);
    wr(8'h1C, 32'h200); rd(8'h1C, d); check("R11 later clear", d, 0);

    // random register traffic, R2 R3 R4 R5 R12
    for (int i = 0; i < 300; i++) begin
      logic [7:0] a;
      logic [31:0] v;
      a = ofs_list[$urandom % 6];
      v = $urandom;
      wr(a, v);
      rd(a, d);
      check("R2/R3/R4/R5/R12 random", d, exp_read(a, v));
    end

    summary();
  end
endmodule